// File: doc/BRIEF.md
# Nested Hardware Loop Sequencer

This block runs nested counted loops for a wide-issue core, so that no branch or counter instructions are needed. Before a loop-heavy region, software fills a small bank of loop descriptors through a configuration write port. A descriptor holds these fields:
- a reload flag;
- a start count and an end count;
- a step;
- the address of the first instruction of the loop body;
- the initiation interval of the modulo schedule. A plain loop body of N cycles uses an interval of N.

When a loop body is entered, a push command names one descriptor. The unit copies that descriptor's run-time fields onto a nesting stack. It also initialises the count register tied to the new nesting level. Each time the program counter matches the body start of the innermost loop, that loop's count moves forward by its step. When the new count equals the end count, the level is popped. A one-cycle done pulse then reports which descriptor finished.

All count registers are exported in parallel, so the address generators can form strided addresses from any level of the nest. The stack depth equals the number of count registers. Stack level k always uses count register k.

Top module: `loop_seq_unit`

## Requirements
- R1: A configuration write stores all six descriptor fields at the given index. Those fields govern every later push of that descriptor.
- R2: A push that is accepted has the following effects one cycle later:
  - the depth rises by one;
  - the current index shows the pushed descriptor and the current interval shows its interval;
  - the count register at the new level (register number = old depth) holds the start count if the reload flag is 1, or zero if the reload flag is 0.
- R3: When a loop is active, pc_valid is high and pc equals the innermost body start, the innermost count increases by its step on the next cycle. Other pc values leave every count unchanged.
- R4: When the increased count equals the end count, the following happen in the same update:
  - the level is popped and the depth falls by one;
  - the count register keeps the end value;
  - done_o is high for exactly one cycle, with done_idx_o set to the finished descriptor.
- R5: Counts of outer levels keep their values while inner levels run. A pc equal to an outer body start has no effect while an inner level is on top. After the inner level pops, the outer level resumes on its own body start.
- R6: A push while the stack holds DEPTH entries raises ovf_o for one cycle and changes neither the depth, the current index nor any count.
- R7: With the stack empty, pop_en and pc matches are ignored: the depth stays 0, no done pulse is given, and the counts do not change.
- R8: A configuration write to a descriptor that is on the stack does not alter the running level. It takes effect at the next push of that descriptor.
- R9: cur_ii_o shows the interval of the innermost active loop, and 0 when the stack is empty.
- R10: Within one cycle, push takes priority over pop_en, and pop_en takes priority over a pc match. A lower-priority command in the same cycle is dropped.
- R11: After reset the depth is 0, all counts are 0, and done_o and ovf_o are low.
- R12: pop_en on a non-empty stack removes the innermost level with a done pulse for its descriptor. The counts are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_idx | input | IW | Descriptor index to write |
| cfg_reload | input | 1 | 1: load start count on push, 0: clear to zero |
| cfg_start | input | CNT_W | Start count |
| cfg_end | input | CNT_W | End count |
| cfg_step | input | CNT_W | Step added on each body entry |
| cfg_body_pc | input | PC_W | First instruction address of the body |
| cfg_ii | input | II_W | Initiation interval |
| push_en | input | 1 | Enter a nested loop |
| push_idx | input | IW | Descriptor to enter |
| pop_en | input | 1 | Leave the innermost loop early |
| pc_valid | input | 1 | pc carries a valid issue address |
| pc | input | PC_W | Current program counter |
| counts_o | output | DEPTH*CNT_W | All count registers, register k at bits k*CNT_W upward |
| depth_o | output | DW | Current nesting depth |
| active_o | output | 1 | At least one loop is active |
| cur_idx_o | output | IW | Descriptor of the innermost loop (0 when idle) |
| cur_ii_o | output | II_W | Interval of the innermost loop (0 when idle) |
| done_o | output | 1 | One-cycle pulse on every pop |
| done_idx_o | output | IW | Descriptor that was popped |
| ovf_o | output | 1 | One-cycle pulse on a rejected push |

## Verification
Count advance is tried with both reload flavours and with steps of 1, 3 and 4. Mixing these separates the load-start path from the clear path, and the step adder from a plain increment. Interleaved matching and non-matching pc values show that only the innermost body start advances a count. A pc on an outer body start during an inner loop confirms that levels are kept apart. Running the stack to full, and then past full and past empty, exposes the guards at both ends. Rewriting a live descriptor, and issuing push, pop and pc match in the same cycle, exposes the snapshot and priority rules.

// File: rtl/lpu_pkg.sv
package lpu_pkg;
   localparam int CNT_W = 16;
   localparam int PC_W  = 16;
   localparam int II_W  = 6;

   // full descriptor as written by software
   typedef struct packed {
      logic              reload;
      logic [CNT_W-1:0]  start_v;
      logic [CNT_W-1:0]  end_v;
      logic [CNT_W-1:0]  step_v;
      logic [PC_W-1:0]   body_pc;
      logic [II_W-1:0]   ii;
   } lctx_t;

   // fields a running level needs after entry
   typedef struct packed {
      logic [CNT_W-1:0]  end_v;
      logic [CNT_W-1:0]  step_v;
      logic [PC_W-1:0]   body_pc;
      logic [II_W-1:0]   ii;
   } lrun_t;
endpackage

// File: rtl/lpu_ctx_file.sv
module lpu_ctx_file
   import lpu_pkg::*;
#(
   parameter int NUM_CTX = 8,
   localparam int IW = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_idx,
   input  lctx_t         wr_data,
   input  logic [IW-1:0] rd_idx,
   output lctx_t         rd_data
);
   lctx_t regs_q [NUM_CTX];

   for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            regs_q[c] <= '0;
         else if (wr_en && wr_idx == IW'(c))
            regs_q[c] <= wr_data;
      end
   end

   // read returns the pre-write value when read and write collide
   always_comb begin
      rd_data = '0;
      for (int c = 0; c < NUM_CTX; c++)
         if (rd_idx == IW'(c)) rd_data = regs_q[c];
   end
endmodule

// File: rtl/lpu_stack.sv
module lpu_stack
   import lpu_pkg::*;
#(
   parameter int DEPTH = 4,
   parameter int IW    = 3,
   localparam int DW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [IW-1:0] push_idx,
   input  lrun_t         push_run,
   input  logic          pop,
   output logic [DW-1:0] depth,
   output logic [IW-1:0] top_idx,
   output lrun_t         top_run
);
   logic [IW-1:0] idx_q [DEPTH];
   lrun_t         run_q [DEPTH];
   logic [DW-1:0] depth_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         depth_q <= '0;
      else if (push && depth_q < DW'(DEPTH))
         depth_q <= depth_q + DW'(1);
      else if (pop && depth_q != '0)
         depth_q <= depth_q - DW'(1);
   end

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            idx_q[e] <= '0;
            run_q[e] <= '0;
         end else if (push && depth_q == DW'(e)) begin
            idx_q[e] <= push_idx;
            run_q[e] <= push_run;
         end
      end
   end

   always_comb begin
      top_idx = '0;
      top_run = '0;
      for (int e = 0; e < DEPTH; e++)
         if (depth_q == DW'(e + 1)) begin
            top_idx = idx_q[e];
            top_run = run_q[e];
         end
   end

   assign depth = depth_q;

   // R6
   depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      depth_q <= DW'(DEPTH));
endmodule

// File: rtl/lpu_count_bank.sv
module lpu_count_bank
   import lpu_pkg::*;
#(
   parameter int NUM = 4,
   localparam int LW = (NUM > 1) ? $clog2(NUM) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ld_en,
   input  logic [LW-1:0]        ld_sel,
   input  logic [CNT_W-1:0]     ld_val,
   input  logic                 up_en,
   input  logic [LW-1:0]        up_sel,
   input  logic [CNT_W-1:0]     up_val,
   output logic [NUM*CNT_W-1:0] counts
);
   for (genvar g = 0; g < NUM; g++) begin : g_cnt
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cnt_q <= '0;
         else if (ld_en && ld_sel == LW'(g))
            cnt_q <= ld_val;
         else if (up_en && up_sel == LW'(g))
            cnt_q <= up_val;
      end
      assign counts[g*CNT_W +: CNT_W] = cnt_q;
   end

   // R10
   excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ld_en && up_en));
endmodule

// File: rtl/loop_seq_unit.sv
module loop_seq_unit
   import lpu_pkg::*;
#(
   parameter int NUM_CTX = 8,
   parameter int DEPTH   = 4,
   localparam int IW = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
   localparam int DW = $clog2(DEPTH + 1),
   localparam int LW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_we,
   input  logic [IW-1:0]          cfg_idx,
   input  logic                   cfg_reload,
   input  logic [CNT_W-1:0]       cfg_start,
   input  logic [CNT_W-1:0]       cfg_end,
   input  logic [CNT_W-1:0]       cfg_step,
   input  logic [PC_W-1:0]        cfg_body_pc,
   input  logic [II_W-1:0]        cfg_ii,
   input  logic                   push_en,
   input  logic [IW-1:0]          push_idx,
   input  logic                   pop_en,
   input  logic                   pc_valid,
   input  logic [PC_W-1:0]        pc,
   output logic [DEPTH*CNT_W-1:0] counts_o,
   output logic [DW-1:0]          depth_o,
   output logic                   active_o,
   output logic [IW-1:0]          cur_idx_o,
   output logic [II_W-1:0]        cur_ii_o,
   output logic                   done_o,
   output logic [IW-1:0]          done_idx_o,
   output logic                   ovf_o
);
   if (DEPTH < 1) begin : g_bad_depth
      $error("loop_seq_unit: DEPTH must be at least 1");
   end
   if (NUM_CTX < 2) begin : g_bad_ctx
      $error("loop_seq_unit: NUM_CTX must be at least 2");
   end

   lctx_t         wr_ctx, rd_ctx;
   lrun_t         new_run, top_run;
   logic [DW-1:0] depth;
   logic [IW-1:0] top_idx;
   logic          full, empty;
   logic          do_push, do_popcmd, match, finish, do_pop;
   logic [LW-1:0] lvl_new, lvl_top;
   logic [CNT_W-1:0] cur_cnt, next_cnt;

   assign wr_ctx = '{reload: cfg_reload, start_v: cfg_start, end_v: cfg_end,
                     step_v: cfg_step, body_pc: cfg_body_pc, ii: cfg_ii};

   lpu_ctx_file #(.NUM_CTX(NUM_CTX)) u_ctx (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cfg_we), .wr_idx(cfg_idx), .wr_data(wr_ctx),
      .rd_idx(push_idx), .rd_data(rd_ctx)
   );

   assign new_run = '{end_v: rd_ctx.end_v, step_v: rd_ctx.step_v,
                      body_pc: rd_ctx.body_pc, ii: rd_ctx.ii};

   assign full  = (depth == DW'(DEPTH));
   assign empty = (depth == '0);

   // priority: push, then explicit pop, then pc match
   assign do_push   = push_en && !full;
   assign do_popcmd = !push_en && pop_en && !empty;
   assign match     = !push_en && !pop_en && !empty && pc_valid
                      && (pc == top_run.body_pc);

   assign lvl_new  = LW'(depth);
   assign lvl_top  = LW'(depth - DW'(1));
   assign cur_cnt  = counts_o[int'(lvl_top)*CNT_W +: CNT_W];
   assign next_cnt = cur_cnt + top_run.step_v;
   assign finish   = match && (next_cnt == top_run.end_v);
   assign do_pop   = do_popcmd || finish;

   lpu_stack #(.DEPTH(DEPTH), .IW(IW)) u_stk (
      .clk(clk), .rst_n(rst_n),
      .push(do_push), .push_idx(push_idx), .push_run(new_run),
      .pop(do_pop),
      .depth(depth), .top_idx(top_idx), .top_run(top_run)
   );

   lpu_count_bank #(.NUM(DEPTH)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .ld_en(do_push), .ld_sel(lvl_new),
      .ld_val(rd_ctx.reload ? rd_ctx.start_v : '0),
      .up_en(match), .up_sel(lvl_top), .up_val(next_cnt),
      .counts(counts_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_o     <= 1'b0;
         done_idx_o <= '0;
         ovf_o      <= 1'b0;
      end else begin
         done_o     <= do_pop;
         done_idx_o <= do_pop ? top_idx : done_idx_o;
         ovf_o      <= push_en && full;
      end
   end

   assign depth_o   = depth;
   assign active_o  = !empty;
   assign cur_idx_o = empty ? '0 : top_idx;
   assign cur_ii_o  = empty ? '0 : top_run.ii;

   // R2
   push_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push_en && !full) |=> depth_o == $past(depth_o) + DW'(1));

   // R6
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push_en && full) |=> (ovf_o && $stable(depth_o) && $stable(counts_o)));

   // R4
   done_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> depth_o == $past(depth_o) - DW'(1));

   // R7
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!active_o && !push_en) |=> ($stable(counts_o) && depth_o == '0 && !done_o));

   // R3
   count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!push_en && !(pc_valid && active_o)) |=> $stable(counts_o));
endmodule

// File: tb/loop_seq_unit_test.sv
module loop_seq_unit_test;
   import lpu_pkg::*;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 0, cfg_reload = 0, push_en = 0, pop_en = 0, pc_valid = 0;
   logic [2:0] cfg_idx = 0, push_idx = 0;
   logic [CNT_W-1:0] cfg_start = 0, cfg_end = 0, cfg_step = 0;
   logic [PC_W-1:0] cfg_body_pc = 0, pc = 0;
   logic [II_W-1:0] cfg_ii = 0;
   logic [4*CNT_W-1:0] counts;
   logic [2:0] depth;
   logic active, done, ovf;
   logic [2:0] cur_idx, done_idx;
   logic [II_W-1:0] cur_ii;
   int checks = 0, errors = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   loop_seq_unit uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_reload(cfg_reload), .cfg_start(cfg_start), .cfg_end(cfg_end),
      .cfg_step(cfg_step), .cfg_body_pc(cfg_body_pc), .cfg_ii(cfg_ii),
      .push_en(push_en), .push_idx(push_idx), .pop_en(pop_en),
      .pc_valid(pc_valid), .pc(pc), .counts_o(counts), .depth_o(depth),
      .active_o(active), .cur_idx_o(cur_idx), .cur_ii_o(cur_ii),
      .done_o(done), .done_idx_o(done_idx), .ovf_o(ovf)
   );

   function automatic int cnt(int k);
      return int'(counts[k*CNT_W +: CNT_W]);
   endfunction

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk); #1;
      cfg_we = 0; push_en = 0; pop_en = 0; pc_valid = 0;
   endtask

   task automatic do_cfg(int idx, int rl, int st, int en, int sp, int bpc, int ii);
      cfg_we = 1; cfg_idx = 3'(idx); cfg_reload = rl[0];
      cfg_start = CNT_W'(st); cfg_end = CNT_W'(en); cfg_step = CNT_W'(sp);
      cfg_body_pc = PC_W'(bpc); cfg_ii = II_W'(ii);
      tick();
   endtask

   task automatic do_push(int idx);
      push_en = 1; push_idx = 3'(idx); tick();
   endtask

   task automatic do_pc(int a);
      pc_valid = 1; pc = PC_W'(a); tick();
   endtask

   task automatic do_pop;
      pop_en = 1; tick();
   endtask

   task automatic t_reset;
      chk("R11 depth", int'(depth), 0);
      for (int k = 0; k < 4; k++) chk("R11 count", cnt(k), 0);
      chk("R11 done", int'(done), 0);
      chk("R11 ovf", int'(ovf), 0);
   endtask

   task automatic t_single;
      do_cfg(0, 1, 5, 8, 1, 'h100, 3);
      do_push(0);
      chk("R2 depth", int'(depth), 1);
      chk("R2 reload start", cnt(0), 5);
      chk("R2 cur idx", int'(cur_idx), 0);
      chk("R9 cur ii", int'(cur_ii), 3);
      do_pc('h100);
      chk("R3 step", cnt(0), 6);
      do_pc('h104);
      chk("R3 no match", cnt(0), 6);
      do_pc('h100);
      chk("R3 step2", cnt(0), 7);
      chk("R4 no early done", int'(done), 0);
      do_pc('h100);
      chk("R4 end count kept", cnt(0), 8);
      chk("R4 depth", int'(depth), 0);
      chk("R4 done", int'(done), 1);
      chk("R4 done idx", int'(done_idx), 0);
      chk("R9 idle ii", int'(cur_ii), 0);
      tick();
      chk("R4 done one cycle", int'(done), 0);
   endtask

   task automatic t_clear;
      do_cfg(1, 0, 9, 6, 3, 'h200, 2);
      do_push(1);
      chk("R2 clear on push", cnt(0), 0);
      chk("R1 ii stored", int'(cur_ii), 2);
      do_pc('h200);
      chk("R1 step 3", cnt(0), 3);
      do_pc('h200);
      chk("R4 clear end", cnt(0), 6);
      chk("R4 done idx1", int'(done_idx), 1);
   endtask

   task automatic t_nested;
      do_cfg(2, 1, 0, 2, 1, 'h10, 4);
      do_cfg(3, 1, 0, 3, 1, 'h20, 1);
      do_push(2);
      do_pc('h10);
      chk("R5 outer step", cnt(0), 1);
      do_push(3);
      chk("R5 depth2", int'(depth), 2);
      chk("R5 inner reg", cnt(1), 0);
      chk("R5 cur idx", int'(cur_idx), 3);
      do_pc('h10);
      chk("R5 outer pc ignored c0", cnt(0), 1);
      chk("R5 outer pc ignored c1", cnt(1), 0);
      do_pc('h20); do_pc('h20); do_pc('h20);
      chk("R5 inner end", cnt(1), 3);
      chk("R5 inner done idx", int'(done_idx), 3);
      chk("R5 back to depth1", int'(depth), 1);
      chk("R5 outer kept", cnt(0), 1);
      do_pc('h10);
      chk("R5 outer resumes", cnt(0), 2);
      chk("R5 outer done idx", int'(done_idx), 2);
      chk("R5 depth0", int'(depth), 0);
   endtask

   task automatic t_overflow;
      do_cfg(4, 1, 0, 100, 1, 'h300, 5);
      for (int k = 0; k < 4; k++) do_push(4);
      chk("R6 full depth", int'(depth), 4);
      for (int k = 0; k < 4; k++) chk("R2 level count", cnt(k), 0);
      do_pc('h300);
      chk("R5 top level reg3", cnt(3), 1);
      chk("R5 reg0 untouched", cnt(0), 0);
      do_push(1);
      chk("R6 ovf", int'(ovf), 1);
      chk("R6 depth kept", int'(depth), 4);
      chk("R6 count kept", cnt(3), 1);
      chk("R6 idx kept", int'(cur_idx), 4);
      do_pc('h0);
      chk("R6 ovf one cycle", int'(ovf), 0);
      for (int k = 0; k < 4; k++) begin
         do_pop();
         chk("R12 pop done", int'(done), 1);
      end
      chk("R12 depth0", int'(depth), 0);
      chk("R12 counts kept", cnt(3), 1);
      do_pop();
      chk("R7 pop empty depth", int'(depth), 0);
      chk("R7 pop empty done", int'(done), 0);
      do_pc('h300);
      chk("R7 pc empty", cnt(3), 1);
   endtask

   task automatic t_live_write;
      do_cfg(5, 1, 0, 10, 1, 'h400, 1);
      do_push(5);
      do_cfg(5, 1, 2, 12, 4, 'h400, 7);
      chk("R8 ii unchanged", int'(cur_ii), 1);
      do_pc('h400);
      chk("R8 old step", cnt(0), 1);
      do_pop();
      do_push(5);
      chk("R8 new start", cnt(0), 2);
      chk("R8 new ii", int'(cur_ii), 7);
      do_pc('h400);
      chk("R8 new step", cnt(0), 6);
      do_pop();
   endtask

   task automatic t_priority;
      do_cfg(6, 1, 0, 50, 1, 'h500, 2);
      do_push(6);
      push_en = 1; push_idx = 6; pc_valid = 1; pc = 'h500; tick();
      chk("R10 push wins depth", int'(depth), 2);
      chk("R10 pc dropped", cnt(0), 0);
      pop_en = 1; pc_valid = 1; pc = 'h500; tick();
      chk("R10 pop wins depth", int'(depth), 1);
      chk("R10 pop done idx", int'(done_idx), 6);
      chk("R10 pc dropped c0", cnt(0), 0);
      do_pc('h500);
      chk("R10 level0 live", cnt(0), 1);
      push_en = 1; push_idx = 6; pop_en = 1; tick();
      chk("R10 push over pop", int'(depth), 2);
      chk("R10 no done", int'(done), 0);
      do_pop(); do_pop();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: got 1 expected 0");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      tick();
      t_reset();
      t_single();
      t_clear();
      t_nested();
      t_overflow();
      t_live_write();
      t_priority();
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule